// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block produces the column address for every beat of an SDRAM read or write burst. When a column command starts, it captures the start column and the burst settings from the mode register. These settings are a length code, an ordering bit and a single-write bit. From the next cycle it presents one column per clock with a beat-valid strobe. A last-beat flag marks the final beat of a fixed-length burst.

Fixed bursts of 1, 2, 4 or 8 beats only change the low bits of the column. The remaining upper bits hold the start value. The low bits follow one of two orderings:
- wrap-around counting inside the aligned block, or
- the start offset XORed with the beat index.

A full-page burst counts up through the whole row, wraps at the row end, and runs until a terminate pulse stops it. The command logic can restart the sequencer on any cycle with a new start column.

Top module: `burst_col_seq`

## Requirements
- R1: While reset is asserted and after its release, beat_valid_o and last_o are low until an accepted start.
- R2: An accepted start at a clock edge makes beat_valid_o high from the next cycle, with col_o equal to the start column on that first beat. One further beat follows on every later cycle.
- R3: Length codes 000, 001, 010 and 011 give bursts of 1, 2, 4 and 8 beats. last_o is high on the final beat only, and beat_valid_o is low in the cycle after it unless a new start was accepted.
- R4: With the ordering bit 0 (sequential), the low log2(L) column bits on beat i equal (start + i) mod L, and the upper bits keep the start value. Example: length 4 from low offset 1 gives 1,2,3,0.
- R5: With the ordering bit 1 (interleaved), the low log2(L) column bits on beat i equal start XOR i, and the upper bits keep the start value. Example: length 8 from 6 gives 6,7,4,5,2,3,0,1.
- R6: Length code 111 with the ordering bit 0 is full page. The column on beat i is (start + i) mod 2^COL_W, last_o is never raised, and beats continue until a terminate pulse.
- R7: A start with length code 100, 101 or 110, or with code 111 and the ordering bit 1, is ignored. Outputs continue exactly as if no start had been given.
- R8: When is_write_i and single_write_i are both 1 at an accepted start, the burst is one beat long whatever the length code. With is_write_i at 0, the programmed length applies.
- R9: A terminate pulse with no accepted start in the same cycle makes beat_valid_o low in the next cycle.
- R10: An accepted start during a burst restarts sequencing next cycle at the new start column with the new settings. A start and a terminate in the same cycle act as the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Column command accepted this cycle |
| term_i | input | 1 | Burst terminate pulse |
| is_write_i | input | 1 | 1 for a write command, 0 for a read |
| start_col_i | input | COL_W | Start column of the command |
| len_code_i | input | 3 | Burst length code |
| interleave_i | input | 1 | Ordering: 0 sequential, 1 interleaved |
| single_write_i | input | 1 | Force write bursts to a single beat |
| col_o | output | COL_W | Column for the current beat |
| beat_valid_o | output | 1 | A beat is presented this cycle |
| last_o | output | 1 | Final beat of a fixed-length burst |

## Verification
The hardest case to reach is the wrap of a full-page burst past the top of the row, which takes up to 2^COL_W beats. A random burst is usually interrupted by a new start or a terminate long before it gets there. A directed case starts a full-page burst three columns below the row end and runs it across the wrap. Random traffic restarts bursts at random points so that restarts, same-cycle start and terminate, and rejected reserved codes all land in the middle of live bursts.

// File: rtl/burst_col_seq.sv
module burst_col_seq #(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             term_i,
  input  logic             is_write_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [2:0]       len_code_i,
  input  logic             interleave_i,
  input  logic             single_write_i,
  output logic [COL_W-1:0] col_o,
  output logic             beat_valid_o,
  output logic             last_o
);

  localparam logic [2:0] CODE_FULL = 3'b111;

  logic             active_q, full_q, ilv_q;
  logic [1:0]       lg_q;
  logic [COL_W-1:0] base_q, beat_q;
  logic [COL_W-1:0] mask_w, low_w;
  logic             legal_w, go_w, one_w;

  assign legal_w = !len_code_i[2] || (len_code_i == CODE_FULL && !interleave_i);
  assign go_w    = start_i && legal_w;
  assign one_w   = is_write_i && single_write_i;

  assign mask_w = full_q ? {COL_W{1'b1}} : ~({COL_W{1'b1}} << lg_q);
  assign low_w  = ilv_q ? (base_q ^ beat_q) : (base_q + beat_q);

  assign col_o        = (base_q & ~mask_w) | (low_w & mask_w);
  assign beat_valid_o = active_q;
  assign last_o       = active_q && !full_q && (beat_q == mask_w);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      full_q   <= 1'b0;
      ilv_q    <= 1'b0;
      lg_q     <= '0;
      base_q   <= '0;
      beat_q   <= '0;
    end else if (go_w) begin
      active_q <= 1'b1;
      base_q   <= start_col_i;
      beat_q   <= '0;
      ilv_q    <= interleave_i;
      full_q   <= !one_w && (len_code_i == CODE_FULL);
      lg_q     <= (one_w || len_code_i == CODE_FULL) ? 2'd0 : len_code_i[1:0];
    end else if (term_i) begin
      active_q <= 1'b0;
    end else if (active_q) begin
      if (last_o) active_q <= 1'b0;
      else        beat_q   <= beat_q + COL_W'(1);
    end
  end

  AST_LAST_HAS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |-> beat_valid_o);                                            // R3

  AST_START_FIRST_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    go_w |=> (beat_valid_o && col_o == $past(start_col_i)));             // R2

  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (last_o && !start_i) |=> !beat_valid_o);                             // R3

  AST_FULL_NO_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && len_code_i == CODE_FULL && !interleave_i && !one_w) |=> !last_o); // R6

  AST_SINGLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (go_w && one_w) |=> last_o);                                         // R8

  AST_TERM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (term_i && !start_i) |=> !beat_valid_o);                             // R9

  AST_KEEP_GOING: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid_o && !last_o && !term_i) |=> beat_valid_o);              // R2

endmodule

// File: tb/burst_col_seq_tb.sv
`timescale 1ns/1ps
module burst_col_seq_tb;
  localparam int COL_W = 8;

  logic clk = 0, rst_n = 0;
  logic start_i = 0, term_i = 0, is_write_i = 0, interleave_i = 0, single_write_i = 0;
  logic [COL_W-1:0] start_col_i = '0;
  logic [2:0] len_code_i = '0;
  logic [COL_W-1:0] col_o;
  logic beat_valid_o, last_o;

  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  burst_col_seq #(.COL_W(COL_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .term_i(term_i),
    .is_write_i(is_write_i), .start_col_i(start_col_i), .len_code_i(len_code_i),
    .interleave_i(interleave_i), .single_write_i(single_write_i),
    .col_o(col_o), .beat_valid_o(beat_valid_o), .last_o(last_o));

  bit               m_act = 0, m_ilv = 0;
  logic [COL_W-1:0] m_base = '0, m_beat = '0;
  int               m_len = 1;
  string            cur_tag = "R1";

  function automatic logic [COL_W-1:0] exp_col(logic [COL_W-1:0] b, logic [COL_W-1:0] i,
                                               int len, bit il);
    logic [COL_W-1:0] mk, lo;
    if (len == 0) return b + i;
    mk = COL_W'(len - 1);
    lo = il ? (b ^ i) : (b + i);
    return (b & ~mk) | (lo & mk);
  endfunction

  function automatic bit exp_last();
    return m_act && m_len != 0 && m_beat == COL_W'(m_len - 1);
  endfunction

  task automatic check_now();
    n_chk++;
    if (beat_valid_o !== m_act) begin
      n_bad++;
      $display("FAIL %s valid: got %0b exp %0b", cur_tag, beat_valid_o, m_act);
    end
    if (m_act) begin
      n_chk++;
      if (col_o !== exp_col(m_base, m_beat, m_len, m_ilv)) begin
        n_bad++;
        $display("FAIL %s col: got %0h exp %0h", cur_tag, col_o,
                 exp_col(m_base, m_beat, m_len, m_ilv));
      end
    end
    n_chk++;
    if (last_o !== exp_last()) begin
      n_bad++;
      $display("FAIL %s last: got %0b exp %0b", cur_tag, last_o, exp_last());
    end
  endtask

  task automatic cyc(string t, bit s, bit te, bit wr, logic [COL_W-1:0] c,
                     logic [2:0] code, bit il, bit sw);
    bit lgl, lst;
    @(negedge clk);
    check_now();
    cur_tag = t;
    start_i = s; term_i = te; is_write_i = wr; start_col_i = c;
    len_code_i = code; interleave_i = il; single_write_i = sw;
    lgl = (code <= 3'd3) || (code == 3'b111 && !il);
    lst = exp_last();
    if (s && lgl) begin
      m_act = 1; m_base = c; m_beat = '0; m_ilv = il;
      m_len = (wr && sw) ? 1 : (code == 3'b111) ? 0 : (1 << code);
    end else if (te) m_act = 0;
    else if (m_act) begin
      if (lst) m_act = 0;
      else m_beat = m_beat + COL_W'(1);
    end
  endtask

  task automatic idle(string t, int n);
    for (int k = 0; k < n; k++) cyc(t, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) begin
      @(negedge clk);
      n_chk++;
      if (beat_valid_o !== 1'b0 || last_o !== 1'b0) begin
        n_bad++;
        $display("FAIL R1 reset: got %0b%0b exp 00", beat_valid_o, last_o);
      end
    end
    rst_n = 1;
    idle("R1", 2);
    // R3 every fixed length, sequential
    for (int cd = 0; cd < 4; cd++) begin
      cyc("R3", 1, 0, 0, 8'h35, 3'(cd), 0, 0);
      idle("R3", 10);
    end
    // R4 sequential wrap, R2 first beat
    cyc("R4", 1, 0, 0, 8'h41, 3'd2, 0, 0); idle("R4", 6);
    cyc("R2", 1, 0, 0, 8'h25, 3'd3, 0, 0); idle("R4", 10);
    // R5 interleaved
    cyc("R5", 1, 0, 0, 8'h11, 3'd2, 1, 0); idle("R5", 6);
    cyc("R5", 1, 0, 0, 8'h76, 3'd3, 1, 0); idle("R5", 10);
    // R6 full page across the row end
    cyc("R6", 1, 0, 0, 8'hFD, 3'd7, 0, 0); idle("R6", 8);
    cyc("R9", 0, 1, 0, 0, 0, 0, 0); idle("R9", 3);
    // R7 reserved codes while idle and during a burst
    cyc("R7", 1, 0, 0, 8'h22, 3'd4, 0, 0); idle("R7", 3);
    cyc("R7", 1, 0, 0, 8'h30, 3'd3, 0, 0);
    cyc("R7", 1, 0, 0, 8'h99, 3'd7, 1, 0);
    cyc("R7", 1, 0, 0, 8'h99, 3'd6, 0, 0); idle("R7", 10);
    // R8 single write versus read
    cyc("R8", 1, 0, 1, 8'h63, 3'd3, 0, 1); idle("R8", 4);
    cyc("R8", 1, 0, 1, 8'h63, 3'd7, 0, 1); idle("R8", 4);
    cyc("R8", 1, 0, 0, 8'h63, 3'd3, 0, 1); idle("R8", 10);
    // R9 terminate mid burst
    cyc("R9", 1, 0, 0, 8'h80, 3'd3, 0, 0); idle("R9", 2);
    cyc("R9", 0, 1, 0, 0, 0, 0, 0); idle("R9", 3);
    // R10 restart and start+terminate together
    cyc("R10", 1, 0, 0, 8'h10, 3'd3, 0, 0); idle("R10", 2);
    cyc("R10", 1, 0, 0, 8'hC6, 3'd2, 1, 0);
    cyc("R10", 1, 1, 0, 8'h5A, 3'd1, 0, 0); idle("R10", 4);
    // random traffic
    for (int k = 0; k < 4000; k++) begin
      bit s, te, il;
      logic [2:0] cd;
      s  = ($urandom_range(0, 5) == 0);
      te = ($urandom_range(0, 19) == 0);
      il = $urandom_range(0, 1);
      cd = $urandom_range(0, 7);
      cyc(m_len == 0 ? "R6" : (m_ilv ? "R5" : "R4"), s, te, $urandom_range(0, 1),
          COL_W'($urandom), cd, il, ($urandom_range(0, 3) == 0));
    end
    idle("R3", 10);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule